// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for an LCD panel: a horizontal sync pulse, a vertical sync pulse and a display-enable window. It also reports the current line number, a vsync-active flag and a vertical-blanking flag. On each axis the count starts at 0 with the sync pulse. The back porch, the active region and the front porch follow in that order, and the count wraps after `total - 1`. The vertical counter advances once per wrap of the horizontal counter.

Nine timing values set the raster:

- Horizontal: sync end, display start, active width and total.
- Vertical: sync end, display start, active lines and total.
- A line-match number.

The inputs are sampled into a shadow copy only at the frame boundary, which is the cycle where both counters wrap. A frame therefore always runs with one consistent set of values. The sync polarity and the interrupt mask act at once.

Each axis is described by a decoded phase state. The states are SYNC, BACK, ACTIVE and FRONT. The transitions are:

- SYNC to BACK when the count reaches sync end.
- BACK to ACTIVE at display start.
- ACTIVE to FRONT at display start plus the active length.
- FRONT to SYNC when the count wraps.

A zero-length phase is skipped.

Three interrupt causes are latched into sticky status bits: frame start, display start and line match. The status bits are cleared by pulsing a one on the matching clear input. A mask selects which causes drive the single interrupt output.

Top module: `lcd_raster_timer`

## Requirements
- R1: The horizontal count runs 0 to htotal-1 and wraps (htotal of 0 or 1 wraps every cycle). The raw hsync is active while the count is below `cfg_hsync_end`.
- R2: The line count advances by one on each horizontal wrap, runs 0 to vtotal-1 and wraps. It is output on `line_o`. The raw vsync is active while the line is below `cfg_vsync_end`.
- R3: `de_o` is high exactly when hds <= h < hds+hactive and vds <= line < vds+vactive.
- R4: `vsyncing_o` is high while line < vsync_end. `vblank_o` is high while line < vds or line > vds+vactive. The line vds+vactive itself is not blanking.
- R5: `sync_pol[0]` sets the hsync polarity and `sync_pol[1]` sets the vsync polarity. A value of 1 makes the pin active-high and 0 makes it active-low. A change takes effect immediately.
- R6: Status bit 0 (frame start) sets one cycle after the counters show h=0 and line=0. Bit 1 (display start) sets one cycle after h=0 and line=vds. Bit 2 (line match) sets one cycle after h=0 and line=`cfg_line_match`. Bits stay set until cleared, and two causes on the same cycle both set.
- R7: A 1 on `irq_clear[i]` clears status bit i at the next edge. It leaves the other bits unchanged. A new event on the same cycle wins over the clear.
- R8: `irq_o` is the OR of `irq_stat_o & irq_mask`. It is low whenever the mask is zero.
- R9: All nine timing inputs are taken into use only at the frame boundary. A line in progress keeps its old length after a mid-frame change.
- R10: While `rst_n` is low, `line_o` is 0, `irq_stat_o` is 0 and `irq_o` is 0. After reset, built-in default timing applies until the first frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hsync_end | input | 16 | Horizontal count where hsync ends |
| cfg_hdisp_start | input | 16 | Horizontal count where active pixels begin |
| cfg_hactive | input | 16 | Active pixels per line |
| cfg_htotal | input | 16 | Pixels per line |
| cfg_vsync_end | input | 16 | Line where vsync ends |
| cfg_vdisp_start | input | 16 | First active line |
| cfg_vactive | input | 16 | Number of active lines |
| cfg_vtotal | input | 16 | Lines per frame |
| cfg_line_match | input | 16 | Line that raises the line-match cause |
| sync_pol | input | 2 | Bit 0 hsync, bit 1 vsync polarity; 1 = active-high |
| irq_mask | input | 3 | Per-cause interrupt enable |
| irq_clear | input | 3 | Per-cause clear, write-one |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| de_o | output | 1 | Display enable |
| line_o | output | 16 | Current line number |
| vsyncing_o | output | 1 | Vsync-active flag |
| vblank_o | output | 1 | Vertical blanking flag |
| irq_stat_o | output | 3 | Sticky cause bits: 0 frame start, 1 display start, 2 line match |
| irq_o | output | 1 | Masked interrupt |

## Verification
The raster is run with several timing sets and compared with a behavioural model on every cycle. The sets are:

- The built-in defaults, which show reset behaviour and the first boundary load.
- A wide set with distinct porches.
- A set whose line-match line equals display start, which shows two causes setting on one cycle.
- A tiny set with no back porch and a match on line 0, which shows skipped phases and coincidence with frame start.

All four polarity codes and several mask values are applied. Clear pulses are timed both clear of events and on event cycles, which separates clear from set priority. A mid-frame change of the line total is followed by direct line-length measurements before and after the boundary. These measurements separate shadowed loading from immediate use.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
    typedef enum logic [1:0] {PH_SYNC, PH_BACK, PH_ACTIVE, PH_FRONT} phase_e;

    localparam int NCAUSE   = 3;
    localparam int C_FRAME  = 0;
    localparam int C_DISP   = 1;
    localparam int C_MATCH  = 2;

    localparam int NF       = 9;
    localparam int F_HSE    = 0;
    localparam int F_HDS    = 1;
    localparam int F_HACT   = 2;
    localparam int F_HTOT   = 3;
    localparam int F_VSE    = 4;
    localparam int F_VDS    = 5;
    localparam int F_VACT   = 6;
    localparam int F_VTOT   = 7;
    localparam int F_LINE   = 8;
endpackage

// File: rtl/lcdt_shadow.sv
module lcdt_shadow
    import lcdt_pkg::*;
#(
    parameter int CW = 16,
    parameter logic [NF*CW-1:0] INIT = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [NF-1:0][CW-1:0]   cfg_i,
    output logic [NF-1:0][CW-1:0]   act_o
);
    for (genvar f = 0; f < NF; f++) begin : g_field
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                act_o[f] <= INIT[f*CW +: CW];
            end else if (load_i) begin
                act_o[f] <= cfg_i[f];
            end
        end
    end

    // R9: timing in use only changes at a frame boundary
    assert_hold_between_frames_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(act_o));
endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis
    import lcdt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    input  logic [CW-1:0] total_i,
    input  logic [CW-1:0] sync_end_i,
    input  logic [CW-1:0] disp_start_i,
    input  logic [CW-1:0] act_len_i,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o,
    output phase_e        phase_o
);
    localparam int EW = CW + 1;

    logic [EW-1:0] cnt_inc;
    logic [EW-1:0] act_end;

    assign cnt_inc = {1'b0, cnt_o} + EW'(1);
    assign act_end = {1'b0, disp_start_i} + {1'b0, act_len_i};
    assign wrap_o  = adv_i && (cnt_inc >= {1'b0, total_i});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (wrap_o) begin
            cnt_o <= '0;
        end else if (adv_i) begin
            cnt_o <= cnt_inc[CW-1:0];
        end
    end

    always_comb begin
        if (cnt_o < sync_end_i) begin
            phase_o = PH_SYNC;
        end else if (cnt_o < disp_start_i) begin
            phase_o = PH_BACK;
        end else if ({1'b0, cnt_o} < act_end) begin
            phase_o = PH_ACTIVE;
        end else begin
            phase_o = PH_FRONT;
        end
    end

    // R1: the count never leaves 0..total-1
    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (total_i != '0) |-> (cnt_o < total_i));
    // R1: a wrap returns the count to 0
    assert_wrap_to_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_o == '0));
    // R2: without an advance the count holds
    assert_hold_no_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(cnt_o));
endmodule

// File: rtl/lcdt_irq.sv
module lcdt_irq
    import lcdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCAUSE-1:0] ev_i,
    input  logic [NCAUSE-1:0] clr_i,
    input  logic [NCAUSE-1:0] mask_i,
    output logic [NCAUSE-1:0] stat_o,
    output logic              irq_o
);
    for (genvar i = 0; i < NCAUSE; i++) begin : g_cause
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat_o[i] <= 1'b0;
            end else if (ev_i[i]) begin
                stat_o[i] <= 1'b1;
            end else if (clr_i[i]) begin
                stat_o[i] <= 1'b0;
            end
        end

        // R6: an event latches
        assert_set_on_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ev_i[i] |=> stat_o[i]);
        // R6: a set bit stays set without a clear
        assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_o[i] && !clr_i[i]) |=> stat_o[i]);
        // R7: a clear without a new event empties the bit
        assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !ev_i[i]) |=> !stat_o[i]);
    end

    assign irq_o = |(stat_o & mask_i);

    // R8: nothing is signalled with all causes masked
    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |-> !irq_o);
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
    import lcdt_pkg::*;
#(
    parameter int CW       = 16,
    parameter int DEF_HSE  = 1,
    parameter int DEF_HDS  = 2,
    parameter int DEF_HACT = 4,
    parameter int DEF_HTOT = 8,
    parameter int DEF_VSE  = 1,
    parameter int DEF_VDS  = 2,
    parameter int DEF_VACT = 3,
    parameter int DEF_VTOT = 7,
    parameter int DEF_LINE = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_hsync_end,
    input  logic [CW-1:0] cfg_hdisp_start,
    input  logic [CW-1:0] cfg_hactive,
    input  logic [CW-1:0] cfg_htotal,
    input  logic [CW-1:0] cfg_vsync_end,
    input  logic [CW-1:0] cfg_vdisp_start,
    input  logic [CW-1:0] cfg_vactive,
    input  logic [CW-1:0] cfg_vtotal,
    input  logic [CW-1:0] cfg_line_match,
    input  logic [1:0]    sync_pol,
    input  logic [2:0]    irq_mask,
    input  logic [2:0]    irq_clear,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic [CW-1:0] line_o,
    output logic          vsyncing_o,
    output logic          vblank_o,
    output logic [2:0]    irq_stat_o,
    output logic          irq_o
);
    localparam int EW = CW + 1;
    localparam logic [NF*CW-1:0] INIT = {
        CW'(DEF_LINE), CW'(DEF_VTOT), CW'(DEF_VACT), CW'(DEF_VDS), CW'(DEF_VSE),
        CW'(DEF_HTOT), CW'(DEF_HACT), CW'(DEF_HDS), CW'(DEF_HSE)};

    logic [NF-1:0][CW-1:0] cfg_vec;
    logic [NF-1:0][CW-1:0] act;
    logic [CW-1:0]         h_cnt;
    logic [CW-1:0]         v_cnt;
    logic                  h_wrap;
    logic                  v_wrap;
    logic                  frame_end;
    phase_e                h_phase;
    phase_e                v_phase;
    logic                  hs_raw, vs_raw, h_act, v_act;
    logic [NCAUSE-1:0]     ev;
    logic                  line_start;

    assign cfg_vec[F_HSE]  = cfg_hsync_end;
    assign cfg_vec[F_HDS]  = cfg_hdisp_start;
    assign cfg_vec[F_HACT] = cfg_hactive;
    assign cfg_vec[F_HTOT] = cfg_htotal;
    assign cfg_vec[F_VSE]  = cfg_vsync_end;
    assign cfg_vec[F_VDS]  = cfg_vdisp_start;
    assign cfg_vec[F_VACT] = cfg_vactive;
    assign cfg_vec[F_VTOT] = cfg_vtotal;
    assign cfg_vec[F_LINE] = cfg_line_match;

    assign frame_end = h_wrap && v_wrap;

    lcdt_shadow #(.CW(CW), .INIT(INIT)) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (frame_end),
        .cfg_i  (cfg_vec),
        .act_o  (act)
    );

    lcdt_axis #(.CW(CW)) u_hax (
        .clk          (clk),
        .rst_n        (rst_n),
        .adv_i        (1'b1),
        .total_i      (act[F_HTOT]),
        .sync_end_i   (act[F_HSE]),
        .disp_start_i (act[F_HDS]),
        .act_len_i    (act[F_HACT]),
        .cnt_o        (h_cnt),
        .wrap_o       (h_wrap),
        .phase_o      (h_phase)
    );

    lcdt_axis #(.CW(CW)) u_vax (
        .clk          (clk),
        .rst_n        (rst_n),
        .adv_i        (h_wrap),
        .total_i      (act[F_VTOT]),
        .sync_end_i   (act[F_VSE]),
        .disp_start_i (act[F_VDS]),
        .act_len_i    (act[F_VACT]),
        .cnt_o        (v_cnt),
        .wrap_o       (v_wrap),
        .phase_o      (v_phase)
    );

    always_comb begin
        hs_raw = 1'b0;
        h_act  = 1'b0;
        unique case (h_phase)
            PH_SYNC:   hs_raw = 1'b1;
            PH_BACK:   ;
            PH_ACTIVE: h_act  = 1'b1;
            PH_FRONT:  ;
        endcase
        vs_raw = 1'b0;
        v_act  = 1'b0;
        unique case (v_phase)
            PH_SYNC:   vs_raw = 1'b1;
            PH_BACK:   ;
            PH_ACTIVE: v_act  = 1'b1;
            PH_FRONT:  ;
        endcase
    end

    assign hsync_o    = sync_pol[0] ? hs_raw : ~hs_raw;
    assign vsync_o    = sync_pol[1] ? vs_raw : ~vs_raw;
    assign de_o       = h_act && v_act;
    assign line_o     = v_cnt;
    assign vsyncing_o = vs_raw;
    assign vblank_o   = (v_cnt < act[F_VDS]) ||
                        ({1'b0, v_cnt} > ({1'b0, act[F_VDS]} + {1'b0, act[F_VACT]}));

    assign line_start  = (h_cnt == '0);
    assign ev[C_FRAME] = line_start && (v_cnt == '0);
    assign ev[C_DISP]  = line_start && (v_cnt == act[F_VDS]);
    assign ev[C_MATCH] = line_start && (v_cnt == act[F_LINE]);

    lcdt_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_i   (ev),
        .clr_i  (irq_clear),
        .mask_i (irq_mask),
        .stat_o (irq_stat_o),
        .irq_o  (irq_o)
    );

    // R4: an enabled pixel is never inside vertical blanking
    assert_de_not_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> !vblank_o);
    // R2: the line number only moves on a horizontal wrap
    assert_line_moves_on_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o != $past(line_o)) |-> $past(h_wrap));
endmodule

// File: tb/sim_lcd_raster_timer.sv
module sim_lcd_raster_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] c_hse, c_hds, c_hact, c_ht, c_vse, c_vds, c_vact, c_vt, c_line;
    logic [1:0]  sync_pol;
    logic [2:0]  irq_mask, irq_clear;
    logic        hsync_o, vsync_o, de_o, vsyncing_o, vblank_o, irq_o;
    logic [15:0] line_o;
    logic [2:0]  irq_stat_o;

    int checks = 0;
    int fails  = 0;
    int hc, vc, st;
    int a[9];
    bit done = 0;

    always #4 clk = ~clk;

    lcd_raster_timer u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_hsync_end(c_hse), .cfg_hdisp_start(c_hds), .cfg_hactive(c_hact),
        .cfg_htotal(c_ht), .cfg_vsync_end(c_vse), .cfg_vdisp_start(c_vds),
        .cfg_vactive(c_vact), .cfg_vtotal(c_vt), .cfg_line_match(c_line),
        .sync_pol(sync_pol), .irq_mask(irq_mask), .irq_clear(irq_clear),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .line_o(line_o),
        .vsyncing_o(vsyncing_o), .vblank_o(vblank_o),
        .irq_stat_o(irq_stat_o), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // behavioural reference: state after each edge
    always @(posedge clk) begin
        int ev;
        if (!rst_n) begin
            hc = 0; vc = 0; st = 0;
            a = '{1, 2, 4, 8, 1, 2, 3, 7, 5};
        end else begin
            ev = 0;
            if (hc == 0 && vc == 0)    ev = ev | 1;
            if (hc == 0 && vc == a[5]) ev = ev | 2;
            if (hc == 0 && vc == a[8]) ev = ev | 4;
            st = (st & ~int'(irq_clear)) | ev;
            if (hc + 1 >= a[3]) begin
                hc = 0;
                if (vc + 1 >= a[7]) begin
                    vc = 0;
                    a = '{int'(c_hse), int'(c_hds), int'(c_hact), int'(c_ht), int'(c_vse),
                          int'(c_vds), int'(c_vact), int'(c_vt), int'(c_line)};
                end else begin
                    vc = vc + 1;
                end
            end else begin
                hc = hc + 1;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        bit hs, vs, ha, va, vb, e_irq;
        if (rst_n && !done) begin
            hs = hc < a[0];
            vs = vc < a[4];
            ha = (hc >= a[1]) && (hc < a[1] + a[2]);
            va = (vc >= a[5]) && (vc < a[5] + a[6]);
            vb = (vc < a[5]) || (vc > a[5] + a[6]);
            e_irq = (st & int'(irq_mask)) != 0;
            chk(hsync_o == (sync_pol[0] ? hs : !hs), "R1/R5 hsync", int'(hsync_o), int'(sync_pol[0] ? hs : !hs));
            chk(vsync_o == (sync_pol[1] ? vs : !vs), "R2/R5 vsync", int'(vsync_o), int'(sync_pol[1] ? vs : !vs));
            chk(int'(line_o) == vc, "R2 line", int'(line_o), vc);
            chk(de_o == (ha && va), "R3 de", int'(de_o), int'(ha && va));
            chk(vsyncing_o == vs, "R4 vsyncing", int'(vsyncing_o), int'(vs));
            chk(vblank_o == vb, "R4 vblank", int'(vblank_o), int'(vb));
            chk(int'(irq_stat_o) == st, "R6/R7 status", int'(irq_stat_o), st);
            chk(irq_o == e_irq, "R8 irq", int'(irq_o), int'(e_irq));
        end
    end

    task automatic set_cfg(input int hse, hds, hact, ht, vse, vds, vact, vt, ln);
        c_hse = 16'(hse); c_hds = 16'(hds); c_hact = 16'(hact); c_ht = 16'(ht);
        c_vse = 16'(vse); c_vds = 16'(vds); c_vact = 16'(vact); c_vt = 16'(vt);
        c_line = 16'(ln);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_clear(input logic [2:0] b);
        @(negedge clk);
        irq_clear = b;
        @(negedge clk);
        irq_clear = 3'b000;
    endtask

    task automatic line_len(output int n);
        logic [15:0] l0, l1;
        @(negedge clk);
        l0 = line_o;
        while (line_o == l0) @(negedge clk);
        l1 = line_o;
        n = 0;
        while (line_o == l1) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int n;
        sync_pol = 2'b11; irq_mask = 3'b000; irq_clear = 3'b000;
        set_cfg(2, 5, 6, 14, 1, 3, 4, 10, 7);
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(line_o == 16'd0, "R10 reset line", int'(line_o), 0);
        chk(irq_stat_o == 3'd0, "R10 reset status", int'(irq_stat_o), 0);
        chk(irq_o == 1'b0, "R10 reset irq", int'(irq_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // defaults first (R10), then the first boundary load (R9)
        run(60);
        irq_mask = 3'b111;
        run(100);
        pulse_clear(3'b001);
        run(37);
        pulse_clear(3'b110);
        sync_pol = 2'b00;
        run(150);
        irq_mask = 3'b010;
        sync_pol = 2'b01;
        pulse_clear(3'b111);
        run(90);
        sync_pol = 2'b10;
        irq_mask = 3'b100;
        run(120);
        // R9: mid-frame change of timing
        while (line_o != 16'd2) @(negedge clk);
        set_cfg(3, 6, 4, 12, 2, 4, 3, 9, 5);
        line_len(n);
        chk(n == 14, "R9 old line length kept", n, 14);
        while (line_o != 16'd0) @(negedge clk);
        line_len(n);
        chk(n == 12, "R9 new line length at boundary", n, 12);
        irq_mask = 3'b111;
        sync_pol = 2'b11;
        // line match on display start line: two causes together (R6)
        set_cfg(1, 2, 5, 9, 1, 2, 3, 8, 2);
        run(250);
        pulse_clear(3'b111);
        run(120);
        // tiny raster, no back porch, match on line 0 (R6, R3)
        set_cfg(1, 1, 1, 3, 1, 1, 1, 4, 0);
        run(150);
        for (int k = 0; k < 12; k++) begin
            // clears landing on assorted cycles, including event cycles (R7)
            irq_clear = 3'(k % 8);
            @(negedge clk);
            irq_clear = 3'b000;
            run(k + 1);
        end
        irq_mask = 3'b000;
        run(40);
        done = 1;
        summary();
        $finish;
    end
endmodule